// File: doc/BRIEF.md
# Sequenced Threshold Lock Trigger

This block watches a swept signal and decides when a feedback loop should be engaged. Every accepted sample enters a moving-window sum whose length is the programmed delay. The output of that window is tested against a short program of steps. Each step has a signed level and a minimum gap, counted in samples. The steps must be met one after another. After the last one, a settle count must run out, and then the engage output goes high and stays high.

In use, a controller first loads the step program, the window delay and the settle count. It then raises the lock request and pulses restart at the start of a sweep. The block does nothing on clock cycles without a valid sample. The step program only moves while the sweep direction input shows a rising sweep.

Top module: `autolock_seq`

## Requirements
- R1: `window_o` equals the signed sum of the last D accepted samples, where D is `delay_i` clamped to MAX_DELAY and samples before a restart count as zero; D = 0 gives 0. An input held at 1000 with D = 5 reads 1000·k after the k-th sample and 5000 from the fifth sample on.
- R2: On a cycle with `sample_valid_i` low, `window_o`, `step_idx_o` and the internal gap counter keep their values.
- R3: A cycle with `restart_i` and `lock_req_i` both high clears the window history, `window_o`, `step_idx_o`, the gap counter and `engage_o` at the next edge. While `lock_req_i` is low, `restart_i` is ignored.
- R4: Step k is packed at bits [k·DIFF_W +: DIFF_W] of `step_level_i` and is compared as a signed DIFF_W value. A level of zero or above is met when the window sum is strictly greater than the level. A negative level is met only when the window sum is strictly below it, so a window sum of the wrong sign never meets it.
- R5: The gap for step k is at bits [k·GAP_W +: GAP_W] of `step_gap_i`. Step k can be met no earlier than the (gap+1)-th sample after the sample that met the previous step, or after the restart for step 0. Each sample that meets a step increments `step_idx_o` by one.
- R6: Only the first min(`n_steps_i`, N_STEP) steps are used. `step_idx_o` never passes that count, and a count of 0 means all steps are already met.
- R7: Once all steps are met, `engage_o` rises at the edge of the (settle+1)-th sample after the last step was met, or after the restart when no steps are used.
- R8: `engage_o` stays high until an edge where `lock_req_i` is low, which clears it, or until a restart. While it is high, the step index and gap counter are frozen.
- R9: While `rising_i` is low, samples still update `window_o`, but `step_idx_o`, the gap counter and `engage_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Signed input sample |
| sample_valid_i | input | 1 | Sample accepted this cycle |
| lock_req_i | input | 1 | Lock request |
| restart_i | input | 1 | Restart the program (needs lock_req_i) |
| rising_i | input | 1 | Sweep is rising; the step program advances only then |
| delay_i | input | TS_W | Window length in samples |
| n_steps_i | input | CNT_W | Number of active steps |
| step_level_i | input | N_STEP·DIFF_W | Packed signed step levels |
| step_gap_i | input | N_STEP·GAP_W | Packed minimum gaps per step |
| settle_i | input | GAP_W | Samples to wait after the last step |
| window_o | output | DIFF_W | Signed window sum |
| step_idx_o | output | CNT_W | Number of steps met |
| engage_o | output | 1 | Turn on the lock |

## Verification
Each result is due at the clock edge that takes the sample. The window sum and step index change at the edge that accepts that sample, and the bench compares them 1 ns after that edge against a model that is updated once per cycle from the same inputs. The engage output is due at the edge of the (settle+1)-th sample after the last step was met. Directed cases check the exact sample counts named in R1, R5, R6 and R7. Stall cycles, falling-sweep cycles and cycles with the request low are checked in the cycle right after, to confirm that nothing moved.

// File: rtl/autolock_pkg.sv
`timescale 1ns/1ps
package autolock_pkg;
  localparam int unsigned DEF_DATA_W    = 14;
  localparam int unsigned DEF_MAX_DELAY = 32;
  localparam int unsigned DEF_N_STEP    = 4;
  localparam int unsigned DEF_GAP_W     = 12;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/sumdiff_window.sv
`timescale 1ns/1ps
module sumdiff_window #(
  parameter int unsigned DATA_W    = 14,
  parameter int unsigned MAX_DELAY = 32,
  parameter int unsigned TS_W      = 6,
  parameter int unsigned DIFF_W    = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     sample_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic [TS_W-1:0]          delay_i,
  output logic signed [DIFF_W-1:0] diff_now_o,
  output logic signed [DIFF_W-1:0] diff_q_o
);
  localparam int unsigned TAP_W = autolock_pkg::clog2_min1(MAX_DELAY);

  logic signed [DATA_W-1:0] line_q [MAX_DELAY];
  logic signed [DIFF_W-1:0] acc_q, new_ext, old_ext;
  logic signed [DATA_W-1:0] old_s;
  logic [TS_W-1:0]          d_eff;
  logic [TAP_W-1:0]         tap;

  always_comb begin
    d_eff = (delay_i > TS_W'(MAX_DELAY)) ? TS_W'(MAX_DELAY) : delay_i;
    tap   = TAP_W'(d_eff - TS_W'(1));
    // zero-length window: the leaving sample is the entering one
    old_s = (d_eff == '0) ? data_i : line_q[tap];
    new_ext = DIFF_W'(data_i);
    old_ext = DIFF_W'(old_s);
    diff_now_o = acc_q + new_ext - old_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
    end else if (sample_i) begin
      acc_q <= diff_now_o;
    end
  end

  generate
    for (genvar g = 0; g < MAX_DELAY; g++) begin : g_line
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          line_q[g] <= '0;
        end else if (clear_i) begin
          line_q[g] <= '0;
        end else if (sample_i) begin
          if (g == 0) line_q[g] <= data_i;
          else        line_q[g] <= line_q[(g > 0) ? g - 1 : 0];
        end
      end
    end
  endgenerate

  assign diff_q_o = acc_q;
endmodule

// File: rtl/instr_sequencer.sv
`timescale 1ns/1ps
module instr_sequencer #(
  parameter int unsigned N_STEP = 4,
  parameter int unsigned DIFF_W = 20,
  parameter int unsigned GAP_W  = 12,
  parameter int unsigned CNT_W  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  input  logic                       enable_i,
  input  logic                       step_i,
  input  logic signed [DIFF_W-1:0]   diff_i,
  input  logic [CNT_W-1:0]           n_steps_i,
  input  logic [N_STEP*DIFF_W-1:0]   level_i,
  input  logic [N_STEP*GAP_W-1:0]    gap_i,
  input  logic [GAP_W-1:0]           settle_i,
  output logic [CNT_W-1:0]           idx_o,
  output logic                       lock_o
);
  localparam int unsigned SEL_W = autolock_pkg::clog2_min1(N_STEP);
  localparam int unsigned N_PAD = 1 << SEL_W;

  logic signed [DIFF_W-1:0] level_arr [N_PAD];
  logic [GAP_W-1:0]         gap_arr   [N_PAD];

  generate
    for (genvar g = 0; g < N_PAD; g++) begin : g_unpack
      if (g < N_STEP) begin : g_used
        assign level_arr[g] = level_i[g*DIFF_W +: DIFF_W];
        assign gap_arr[g]   = gap_i[g*GAP_W +: GAP_W];
      end else begin : g_pad
        assign level_arr[g] = '0;
        assign gap_arr[g]   = '0;
      end
    end
  endgenerate

  logic [CNT_W-1:0]         idx_q, n_eff;
  logic [GAP_W-1:0]         cnt_q, cnt_inc;
  logic                     lock_q, all_met, gap_ok, crossed;
  logic signed [DIFF_W-1:0] cur_lvl;
  logic [GAP_W-1:0]         cur_gap;

  always_comb begin
    n_eff   = (n_steps_i > CNT_W'(N_STEP)) ? CNT_W'(N_STEP) : n_steps_i;
    all_met = (idx_q >= n_eff);
    cur_lvl = level_arr[idx_q[SEL_W-1:0]];
    cur_gap = gap_arr[idx_q[SEL_W-1:0]];
    gap_ok  = (cnt_q >= cur_gap);
    crossed = cur_lvl[DIFF_W-1] ? (diff_i < cur_lvl) : (diff_i > cur_lvl);
    cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + GAP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (restart_i) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!enable_i) begin
      lock_q <= 1'b0;
    end else if (step_i && !lock_q) begin
      if (!all_met) begin
        if (gap_ok && crossed) begin
          idx_q <= idx_q + CNT_W'(1);
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end else if (cnt_q >= settle_i) begin
        lock_q <= 1'b1;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign idx_o  = idx_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/autolock_seq.sv
`timescale 1ns/1ps
module autolock_seq #(
  parameter int unsigned DATA_W    = autolock_pkg::DEF_DATA_W,
  parameter int unsigned MAX_DELAY = autolock_pkg::DEF_MAX_DELAY,
  parameter int unsigned N_STEP    = autolock_pkg::DEF_N_STEP,
  parameter int unsigned GAP_W     = autolock_pkg::DEF_GAP_W,
  localparam int unsigned TS_W     = $clog2(MAX_DELAY + 1),
  localparam int unsigned DIFF_W   = DATA_W + $clog2(MAX_DELAY) + 1,
  localparam int unsigned CNT_W    = $clog2(N_STEP + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [DATA_W-1:0]   data_i,
  input  logic                       sample_valid_i,
  input  logic                       lock_req_i,
  input  logic                       restart_i,
  input  logic                       rising_i,
  input  logic [TS_W-1:0]            delay_i,
  input  logic [CNT_W-1:0]           n_steps_i,
  input  logic [N_STEP*DIFF_W-1:0]   step_level_i,
  input  logic [N_STEP*GAP_W-1:0]    step_gap_i,
  input  logic [GAP_W-1:0]           settle_i,
  output logic signed [DIFF_W-1:0]   window_o,
  output logic [CNT_W-1:0]           step_idx_o,
  output logic                       engage_o
);
  logic                     restart;
  logic signed [DIFF_W-1:0] diff_now;

  assign restart = restart_i && lock_req_i;

  sumdiff_window #(
    .DATA_W(DATA_W), .MAX_DELAY(MAX_DELAY), .TS_W(TS_W), .DIFF_W(DIFF_W)
  ) u_win (
    .clk_i, .rst_ni,
    .clear_i   (restart),
    .sample_i  (sample_valid_i),
    .data_i,
    .delay_i,
    .diff_now_o(diff_now),
    .diff_q_o  (window_o)
  );

  instr_sequencer #(
    .N_STEP(N_STEP), .DIFF_W(DIFF_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .restart_i(restart),
    .enable_i (lock_req_i),
    .step_i   (sample_valid_i && rising_i),
    .diff_i   (diff_now),
    .n_steps_i,
    .level_i  (step_level_i),
    .gap_i    (step_gap_i),
    .settle_i,
    .idx_o    (step_idx_o),
    .lock_o   (engage_o)
  );
endmodule

// File: rtl/autolock_seq_chk.sv
`timescale 1ns/1ps
module autolock_seq_chk #(
  parameter int unsigned DATA_W    = 14,
  parameter int unsigned MAX_DELAY = 32,
  parameter int unsigned N_STEP    = 4,
  parameter int unsigned GAP_W     = 12,
  localparam int unsigned TS_W     = $clog2(MAX_DELAY + 1),
  localparam int unsigned DIFF_W   = DATA_W + $clog2(MAX_DELAY) + 1,
  localparam int unsigned CNT_W    = $clog2(N_STEP + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic signed [DATA_W-1:0] data_i,
  input logic                     sample_valid_i,
  input logic                     lock_req_i,
  input logic                     restart_i,
  input logic                     rising_i,
  input logic [TS_W-1:0]          delay_i,
  input logic [CNT_W-1:0]         n_steps_i,
  input logic [N_STEP*DIFF_W-1:0] step_level_i,
  input logic [N_STEP*GAP_W-1:0]  step_gap_i,
  input logic [GAP_W-1:0]         settle_i,
  input logic signed [DIFF_W-1:0] window_o,
  input logic [CNT_W-1:0]         step_idx_o,
  input logic                     engage_o
);
  // R8
  engage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engage_o && lock_req_i && !restart_i |=> engage_o);
  // R8
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_req_i |=> !engage_o);
  // R3
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i && lock_req_i |=> (step_idx_o == '0) && !engage_o && (window_o == '0));
  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i && !(restart_i && lock_req_i) |=> $stable(window_o) && $stable(step_idx_o));
  // R7
  engage_on_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !engage_o && !sample_valid_i |=> !engage_o);
  // R9
  falling_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rising_i && !(restart_i && lock_req_i) |=> $stable(step_idx_o));
  // R6
  idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_idx_o <= CNT_W'(N_STEP));
  // R5
  idx_step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_i && lock_req_i) && !engage_o |=> (step_idx_o == $past(step_idx_o)) ||
      (step_idx_o == $past(step_idx_o) + CNT_W'(1)));
endmodule

bind autolock_seq autolock_seq_chk #(
  .DATA_W(DATA_W), .MAX_DELAY(MAX_DELAY), .N_STEP(N_STEP), .GAP_W(GAP_W)
) u_chk (.*);

// File: tb/tb_autolock_seq.sv
`timescale 1ns/1ps
module tb_autolock_seq;
  localparam int DATA_W = autolock_pkg::DEF_DATA_W;
  localparam int MAXD   = autolock_pkg::DEF_MAX_DELAY;
  localparam int NS     = autolock_pkg::DEF_N_STEP;
  localparam int GAP_W  = autolock_pkg::DEF_GAP_W;
  localparam int TS_W   = $clog2(MAXD + 1);
  localparam int DIFF_W = DATA_W + $clog2(MAXD) + 1;
  localparam int CNT_W  = $clog2(NS + 1);
  localparam int CNT_MAX = (1 << GAP_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic signed [DATA_W-1:0] x_r = '0;
  logic wr_r = 0, rq_r = 0, st_r = 0, sw_r = 0;
  int cfg_ts = 0, cfg_n = 0, cfg_f = 0;
  int cfg_h [NS];
  int cfg_g [NS];
  logic [NS*DIFF_W-1:0] lvl_bus;
  logic [NS*GAP_W-1:0]  gap_bus;

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      lvl_bus[k*DIFF_W +: DIFF_W] = DIFF_W'(cfg_h[k]);
      gap_bus[k*GAP_W +: GAP_W]   = GAP_W'(cfg_g[k]);
    end
  end

  logic signed [DIFF_W-1:0] window;
  logic [CNT_W-1:0] idx;
  logic engage;

  autolock_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(x_r), .sample_valid_i(wr_r),
    .lock_req_i(rq_r), .restart_i(st_r), .rising_i(sw_r),
    .delay_i(TS_W'(cfg_ts)), .n_steps_i(CNT_W'(cfg_n)),
    .step_level_i(lvl_bus), .step_gap_i(gap_bus), .settle_i(GAP_W'(cfg_f)),
    .window_o(window), .step_idx_o(idx), .engage_o(engage)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_hist [MAXD];
  int m_sum = 0, m_idx = 0, m_cnt = 0;
  bit m_lock = 0;

  task automatic chk(string tag, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int diff, te, ne, lvl;
    bit met;
    if (st_r && rq_r) begin
      for (int k = 0; k < MAXD; k++) m_hist[k] = 0;
      m_sum = 0; m_idx = 0; m_cnt = 0; m_lock = 0;
      return;
    end
    diff = m_sum;
    if (wr_r) begin
      for (int k = MAXD - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = int'(x_r);
      te = (cfg_ts > MAXD) ? MAXD : cfg_ts;
      diff = 0;
      for (int k = 0; k < te; k++) diff += m_hist[k];
    end
    if (!rq_r) m_lock = 0;
    else if (wr_r && sw_r && !m_lock) begin
      ne = (cfg_n > NS) ? NS : cfg_n;
      if (m_idx < ne) begin
        lvl = cfg_h[m_idx];
        met = (lvl >= 0) ? (diff > lvl) : (diff < lvl);
        if (met && m_cnt >= cfg_g[m_idx]) begin m_idx++; m_cnt = 0; end
        else if (m_cnt < CNT_MAX) m_cnt++;
      end else if (m_cnt >= cfg_f) m_lock = 1;
      else if (m_cnt < CNT_MAX) m_cnt++;
    end
    if (wr_r) m_sum = diff;
  endtask

  task automatic tick(int x, bit wr, bit rq, bit st, bit sw, string tag);
    x_r = DATA_W'(x); wr_r = wr; rq_r = rq; st_r = st; sw_r = sw;
    model_step();
    @(posedge clk); #1;
    chk(tag, longint'(window), m_sum, "window");
    chk(tag, longint'(idx), m_idx, "step_idx");
    chk(tag, longint'(engage), m_lock, "engage");
  endtask

  task automatic restart_tick(string tag);
    tick(0, 0, 1, 1, 1, tag);
  endtask

  task automatic set_cfg(int ts, int n, int f);
    cfg_ts = ts; cfg_n = n; cfg_f = f;
    for (int k = 0; k < NS; k++) begin cfg_h[k] = 0; cfg_g[k] = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < MAXD; k++) m_hist[k] = 0;
    set_cfg(5, 1, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R3 reset state
    chk("R3", longint'(window), 0, "reset window");
    chk("R3", longint'(idx), 0, "reset idx");
    chk("R3", longint'(engage), 0, "reset engage");

    // R1 held 1000, delay 5
    set_cfg(5, 1, 0); cfg_h[0] = 300000;
    restart_tick("R1");
    for (int s = 1; s <= 8; s++) begin
      tick(1000, 1, 1, 0, 1, "R1");
      chk("R1", longint'(window), (s < 5) ? 1000 * s : 5000, "window ramp");
    end
    cfg_ts = 0; restart_tick("R1");
    for (int s = 0; s < 3; s++) tick(700, 1, 1, 0, 1, "R1");
    chk("R1", longint'(window), 0, "zero delay");

    // R4 strict positive compare
    set_cfg(5, 1, 0); cfg_h[0] = 5000;
    restart_tick("R4");
    for (int s = 0; s < 10; s++) tick(1000, 1, 1, 0, 1, "R4");
    chk("R4", longint'(idx), 0, "level equal not met");
    cfg_h[0] = 4999; restart_tick("R4");
    for (int s = 0; s < 5; s++) tick(1000, 1, 1, 0, 1, "R4");
    chk("R4", longint'(idx), 1, "level crossed");
    tick(1000, 1, 1, 0, 1, "R4");
    chk("R4", longint'(engage), 1, "engage after single step");

    // R4 negative level, wrong sign never met
    set_cfg(5, 1, 0); cfg_h[0] = -100;
    restart_tick("R4");
    for (int s = 0; s < 20; s++) tick(1000, 1, 1, 0, 1, "R4");
    chk("R4", longint'(idx), 0, "wrong sign ignored");
    for (int s = 0; s < 5; s++) tick(0, 1, 1, 0, 1, "R4");
    for (int s = 0; s < 4; s++) tick(-30, 1, 1, 0, 1, "R4");
    chk("R4", longint'(idx), 1, "negative crossed");

    // R5 gap and R7 settle
    set_cfg(1, 2, 2); cfg_h[0] = 100; cfg_h[1] = 100; cfg_g[1] = 3;
    restart_tick("R5");
    tick(1000, 1, 1, 0, 1, "R5");
    chk("R5", longint'(idx), 1, "first step");
    for (int s = 0; s < 3; s++) tick(1000, 1, 1, 0, 1, "R5");
    chk("R5", longint'(idx), 1, "gap holds");
    tick(1000, 1, 1, 0, 1, "R5");
    chk("R5", longint'(idx), 2, "gap over");
    tick(1000, 1, 1, 0, 1, "R7");
    tick(1000, 1, 1, 0, 1, "R7");
    chk("R7", longint'(engage), 0, "settle running");
    // R2 stall cycles
    for (int s = 0; s < 4; s++) tick(-2000, 0, 1, 0, 1, "R2");
    chk("R2", longint'(engage), 0, "stall no engage");
    tick(1000, 1, 1, 0, 1, "R7");
    chk("R7", longint'(engage), 1, "settle done");
    // R8 hold then drop
    for (int s = 0; s < 6; s++) tick(-5000, 1, 1, 0, 1, "R8");
    chk("R8", longint'(engage), 1, "engage holds");
    tick(0, 1, 0, 0, 1, "R8");
    chk("R8", longint'(engage), 0, "request drop");
    tick(0, 0, 0, 1, 1, "R3");
    chk("R3", longint'(idx), 2, "restart ignored without request");

    // R9 falling sweep freezes program
    set_cfg(1, 1, 0); cfg_h[0] = 10;
    restart_tick("R9");
    for (int s = 0; s < 5; s++) tick(500, 1, 1, 0, 0, "R9");
    chk("R9", longint'(idx), 0, "falling frozen");
    chk("R9", longint'(window), 500, "window still runs");

    // R6 zero and clamped counts
    set_cfg(1, 0, 1);
    restart_tick("R6");
    tick(5, 1, 1, 0, 1, "R6");
    chk("R6", longint'(engage), 0, "zero steps settle");
    tick(5, 1, 1, 0, 1, "R6");
    chk("R6", longint'(engage), 1, "zero steps engage");
    set_cfg(1, 7, 0);
    restart_tick("R6");
    for (int s = 0; s < 4; s++) tick(1000, 1, 1, 0, 1, "R6");
    chk("R6", longint'(idx), NS, "clamped count");
    tick(1000, 1, 1, 0, 1, "R6");
    chk("R6", longint'(engage), 1, "engage after clamp");

    // random episodes, model compared every cycle
    for (int e = 0; e < 40; e++) begin
      set_cfg(1 + int'($urandom_range(7)), int'($urandom_range(5)), int'($urandom_range(6)));
      for (int k = 0; k < NS; k++) begin
        cfg_h[k] = int'($urandom_range(6000)) - 3000;
        cfg_g[k] = int'($urandom_range(5));
      end
      restart_tick("R5");
      for (int c = 0; c < 150; c++) begin
        tick(int'($urandom_range(4000)) - 2000,
             $urandom_range(99) < 85, $urandom_range(99) < 97,
             $urandom_range(99) < 2, $urandom_range(99) < 90, "R4");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule